// File: doc/BRIEF.md
# Address/Data Break Comparator

This unit watches every completed CPU bus cycle and compares it with a programmed 16-bit break address and 16-bit break data. The break data sits in two byte registers: an upper one matched against data-bus bits [15:8] and a lower one matched against bits [7:0]. A control register selects the cycle type (instruction fetch or data access), the direction (read, write or either) and whether the data is compared at all. When every enabled condition holds, a sticky status flag is set. If the interrupt enable is also set, a registered request goes to the CPU. The CPU's global interrupt mask never reaches the unit and cannot block the request.

A byte access carries its data on the upper bus half for both even and odd addresses, so a byte compare uses only the upper break-data byte. A word access at an even address compares both bytes. A word access to an odd address never matches. Software clears the flag by reading it as 1 and then writing 0 to it. The status flag is held in a three-state machine: `FLG_IDLE` (flag clear), `FLG_HIT` (flag set and not yet read) and `FLG_HIT_READ` (flag set and read as 1). Its transitions are:

- `IDLE->HIT` on a match.
- `HIT->HIT_READ` on a status read.
- `HIT_READ->IDLE` on a write of 0 to the flag.
- `HIT_READ->HIT` when a match lands in the same cycle as that clearing write.

Every other case holds its state.

Top module: `brk_match_unit`

## Requirements
- R1: After reset the status flag, the interrupt enable and the request output are 0, and the control and break-address registers read 0x00. The break-data registers have no defined reset value.
- R2: Register map: select 0 is control, 1 is status, 2 and 3 are the break-address high and low bytes, and 4 and 5 are the break-data high and low bytes. Control bit 7 = 1 selects instruction-fetch cycles and 0 selects data cycles. With data compare off, a cycle with `bus_valid`=1, the selected type and `bus_addr` equal to the break address sets the flag. For example, control 0x80 with address 0x025A matches a fetch of 0x025A, but not a fetch of 0x025C and not a data read of 0x025A.
- R3: Control bits [5:4] select the direction: 00 matches reads only, 01 matches writes only, and 10 or 11 matches both. `bus_write`=1 marks a write.
- R4: When control bit 3 (data compare) is 1, a byte access (`bus_word`=0) compares only `bus_data[15:8]` with the high break-data byte, at even and odd addresses alike. `bus_data[7:0]` has no effect.
- R5: When data compare is on, a word access at an even address matches only if both bytes equal their break-data bytes.
- R6: A word access whose address bit 0 is 1 never sets the flag.
- R7: Status register: bit 7 is the flag and bit 6 is the interrupt enable; the other bits read 0. A write of 0 to bit 7 clears the flag only after the flag has been read as 1. A write of 1 to bit 7, or a write of 0 without that prior read, leaves the flag set. A status write always loads bit 6 into the enable.
- R8: `break_irq` equals the flag ANDed with the enable, delayed by one register. It rises one clock after the edge at which the matching cycle sets the flag, and falls one clock after the flag or enable clears. With the enable at 0 it stays 0. No mask input exists.
- R9: Control reads back bits 7, 5, 4 and 3 as written, with the other bits 0. The break-address and break-data bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle completes at this edge |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Data bus, upper half [15:8], lower half [7:0] |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_sel` |
| break_irq | output | 1 | Break interrupt request |

## Verification
The flag is written at the same edge that samples the matching bus cycle, so a status read in the following cycle already shows it. `break_irq` trails the flag by exactly one further edge on both rise and fall. The bench changes every input on the falling clock edge. It samples read data 1 ns after driving the select, and it samples `break_irq` at the falling edge right after the matching cycle (expected 0) and at the falling edge one clock later (expected 1). Clearing is checked the same way: the flag is already 0 at the falling edge after the clearing write, and the request drops one clock after that.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 16;
    localparam int REG_W  = 8;
    localparam int LANES  = BUS_DW / REG_W;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_STAT   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BAR_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BAR_LO = 3'd3;
    localparam logic [SEL_W-1:0] SEL_BDR_HI = 3'd4;
    localparam logic [SEL_W-1:0] SEL_BDR_LO = 3'd5;

    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;

    typedef enum logic [1:0] {
        FLG_IDLE     = 2'd0,
        FLG_HIT      = 2'd1,
        FLG_HIT_READ = 2'd2
    } flag_state_e;

    typedef struct packed {
        logic       fetch;
        logic [1:0] dir;
        logic       dcmp;
    } ctrl_t;

endpackage

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    input  logic                 flag,
    output ctrl_t                ctrl,
    output logic                 ie,
    output logic [BUS_AW-1:0]    bar,
    output logic [BUS_DW-1:0]    bdr,
    output logic [REG_W-1:0]     reg_rdata
);

    ctrl_t             ctrl_q;
    logic              ie_q;
    logic [BUS_AW-1:0] bar_q;
    logic [BUS_DW-1:0] bdr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ie_q   <= 1'b0;
            bar_q  <= '0;
        end else if (reg_we) begin
            unique case (reg_sel)
                SEL_CTRL: begin
                    ctrl_q.fetch <= reg_wdata[7];
                    ctrl_q.dir   <= reg_wdata[5:4];
                    ctrl_q.dcmp  <= reg_wdata[3];
                end
                SEL_STAT:   ie_q <= reg_wdata[IE_BIT];
                SEL_BAR_HI: bar_q[BUS_AW-1:REG_W] <= reg_wdata;
                SEL_BAR_LO: bar_q[REG_W-1:0]      <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Break data has no reset value.
    always_ff @(posedge clk) begin
        if (reg_we && reg_sel == SEL_BDR_HI) bdr_q[BUS_DW-1:REG_W] <= reg_wdata;
        if (reg_we && reg_sel == SEL_BDR_LO) bdr_q[REG_W-1:0]      <= reg_wdata;
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:   reg_rdata = {ctrl_q.fetch, 1'b0, ctrl_q.dir, ctrl_q.dcmp, 3'b000};
            SEL_STAT:   reg_rdata = {flag, ie_q, 6'b000000};
            SEL_BAR_HI: reg_rdata = bar_q[BUS_AW-1:REG_W];
            SEL_BAR_LO: reg_rdata = bar_q[REG_W-1:0];
            SEL_BDR_HI: reg_rdata = bdr_q[BUS_DW-1:REG_W];
            SEL_BDR_LO: reg_rdata = bdr_q[REG_W-1:0];
            default:    reg_rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign ie   = ie_q;
    assign bar  = bar_q;
    assign bdr  = bdr_q;

endmodule

// File: rtl/brk_cmp.sv
module brk_cmp
    import brk_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic              bus_word,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_data,
    input  ctrl_t             ctrl,
    input  logic [BUS_AW-1:0] bar,
    input  logic [BUS_DW-1:0] bdr,
    output logic              hit
);

    localparam int TOP_LANE = LANES - 1;

    logic [LANES-1:0] lane_eq;
    logic type_ok, dir_ok, addr_ok, data_ok, align_ok;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i] = (bus_data[i*REG_W +: REG_W] == bdr[i*REG_W +: REG_W]);
    end

    always_comb begin
        type_ok  = (bus_fetch == ctrl.fetch);
        dir_ok   = ctrl.dir[1] ? 1'b1 : (ctrl.dir[0] ? bus_write : !bus_write);
        addr_ok  = (bus_addr == bar);
        // Byte data always rides on the upper half of the bus.
        data_ok  = !ctrl.dcmp || (bus_word ? (&lane_eq) : lane_eq[TOP_LANE]);
        align_ok = !(bus_word && bus_addr[0]);
        hit      = bus_valid && type_ok && dir_ok && addr_ok && data_ok && align_ok;
    end

endmodule

// File: rtl/brk_flag_fsm.sv
module brk_flag_fsm
    import brk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic stat_rd,
    input  logic clr_wr,
    input  logic ie,
    output logic flag,
    output logic irq
);

    flag_state_e state_q, state_d;
    logic        irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE:     if (hit) state_d = FLG_HIT;
            FLG_HIT:      if (stat_rd) state_d = FLG_HIT_READ;
            FLG_HIT_READ: if (clr_wr) state_d = hit ? FLG_HIT : FLG_IDLE;
            default:      state_d = FLG_IDLE;
        endcase
    end

    assign flag = (state_q != FLG_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= flag && ie;
    end

    assign irq = irq_q;

endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
    import brk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_fetch,
    input  logic        bus_write,
    input  logic        bus_word,
    input  logic [15:0] bus_addr,
    input  logic [15:0] bus_data,
    input  logic [2:0]  reg_sel,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        break_irq
);

    ctrl_t             ctrl;
    logic              ie;
    logic [BUS_AW-1:0] bar;
    logic [BUS_DW-1:0] bdr;
    logic              hit, flag, stat_rd, clr_wr;

    assign stat_rd = reg_re && (reg_sel == SEL_STAT);
    assign clr_wr  = reg_we && (reg_sel == SEL_STAT) && !reg_wdata[FLAG_BIT];

    brk_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .flag      (flag),
        .ctrl      (ctrl),
        .ie        (ie),
        .bar       (bar),
        .bdr       (bdr),
        .reg_rdata (reg_rdata)
    );

    brk_cmp u_cmp (
        .bus_valid (bus_valid),
        .bus_fetch (bus_fetch),
        .bus_write (bus_write),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .ctrl      (ctrl),
        .bar       (bar),
        .bdr       (bdr),
        .hit       (hit)
    );

    brk_flag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .stat_rd (stat_rd),
        .clr_wr  (clr_wr),
        .ie      (ie),
        .flag    (flag),
        .irq     (break_irq)
    );

endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_word,
    input logic [15:0] bus_addr,
    input logic [2:0]  reg_sel,
    input logic        reg_we,
    input logic        wr_bit7,
    input logic        flag,
    input logic        ie,
    input logic        irq,
    input logic [15:0] bar
);

    // The flag only rises after a bus cycle aimed at the break address.
    assert_flag_needs_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(bus_valid) && $past(bus_addr) == $past(bar)));

    assert_odd_word_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_word && bus_addr[0] && !flag) |=> !flag);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_we && reg_sel == 3'd1)) |=> flag);

    assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && reg_we && reg_sel == 3'd1 && wr_bit7) |=> flag);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(ie) && $past(flag)));

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ie) |=> irq);

endmodule

bind brk_match_unit brk_match_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .wr_bit7   (reg_wdata[7]),
    .flag      (flag),
    .ie        (ie),
    .irq       (break_irq),
    .bar       (bar)
);

// File: tb/sim_brk_match_unit.sv
`timescale 1ns/1ps
module sim_brk_match_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
    logic [15:0] bus_addr = '0, bus_data = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        break_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    brk_match_unit u0 (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  ctrl;
        logic [15:0] bar;
        logic [15:0] bdr;
        logic [15:0] addr;
        logic [15:0] data;
        logic        fetch;
        logic        wr;
        logic        word;
        logic        exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 8'h80, 16'h025A, 16'h0000, 16'h025A, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1}, // R2 fetch hit
        '{4'd2, 8'h80, 16'h025A, 16'h0000, 16'h025C, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0}, // R2 other address
        '{4'd2, 8'h80, 16'h025A, 16'h0000, 16'h025A, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 data cycle
        '{4'd2, 8'h00, 16'h0300, 16'h0000, 16'h0300, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1}, // R2 data read hit
        '{4'd3, 8'h00, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 read-only, write
        '{4'd3, 8'h10, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 write-only, write
        '{4'd3, 8'h10, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 write-only, read
        '{4'd3, 8'h20, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 both, write
        '{4'd3, 8'h30, 16'h1000, 16'h0000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 both, read
        '{4'd4, 8'h08, 16'h1001, 16'hA53C, 16'h1001, 16'hA500, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 odd byte upper lane
        '{4'd4, 8'h08, 16'h1000, 16'hA53C, 16'h1000, 16'hA5FF, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 low lane ignored
        '{4'd4, 8'h08, 16'h1000, 16'hA53C, 16'h1000, 16'h3CA5, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 upper mismatch
        '{4'd5, 8'h08, 16'h1000, 16'hA53C, 16'h1000, 16'hA53C, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 word both equal
        '{4'd5, 8'h08, 16'h1000, 16'hA53C, 16'h1000, 16'hA53D, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 low byte differs
        '{4'd6, 8'h00, 16'h1001, 16'h0000, 16'h1001, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 odd word
        '{4'd6, 8'h08, 16'h1001, 16'hA53C, 16'h1001, 16'hA53C, 1'b0, 1'b0, 1'b1, 1'b0}  // R6 odd word, data equal
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic [15:0] d,
                             input logic f, input logic w, input logic wd);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_fetch = f; bus_write = w; bus_word = wd;
        bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic clear_flag(input logic [7:0] stat_val);
        logic [7:0] tmp;
        reg_read(3'd1, tmp);
        reg_write(3'd1, stat_val);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 check("R1 irq", {15'd0, break_irq}, 16'd0);
        reg_read(3'd0, rd); check("R1 ctrl", {8'd0, rd}, 16'h0000);
        reg_read(3'd1, rd); check("R1 status", {8'd0, rd}, 16'h0000);
        reg_read(3'd2, rd); check("R1 bar hi", {8'd0, rd}, 16'h0000);
        reg_read(3'd3, rd); check("R1 bar lo", {8'd0, rd}, 16'h0000);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            reg_write(3'd0, VECS[i].ctrl);
            reg_write(3'd2, VECS[i].bar[15:8]);
            reg_write(3'd3, VECS[i].bar[7:0]);
            reg_write(3'd4, VECS[i].bdr[15:8]);
            reg_write(3'd5, VECS[i].bdr[7:0]);
            clear_flag(8'h00);
            bus_cycle(VECS[i].addr, VECS[i].data, VECS[i].fetch, VECS[i].wr, VECS[i].word);
            reg_read(3'd1, rd);
            check($sformatf("R%0d vector %0d flag", VECS[i].req, i), {15'd0, rd[7]}, {15'd0, VECS[i].exp});
        end

        // R8 request timing with enable on
        clear_flag(8'h00);
        reg_write(3'd0, 8'h80);
        reg_write(3'd2, 8'h02);
        reg_write(3'd3, 8'h5A);
        reg_write(3'd1, 8'h40);
        bus_cycle(16'h025A, 16'h0000, 1'b1, 1'b0, 1'b1);
        #1 check("R8 irq not yet", {15'd0, break_irq}, 16'd0);
        @(negedge clk);
        #1 check("R8 irq one clock later", {15'd0, break_irq}, 16'd1);

        // R7 clear protocol
        reg_write(3'd1, 8'h40);
        reg_read(3'd1, rd); check("R7 write 0 without read keeps flag", {8'd0, rd}, 16'h00C0);
        reg_write(3'd1, 8'hC0);
        reg_read(3'd1, rd); check("R7 write 1 keeps flag", {8'd0, rd}, 16'h00C0);
        reg_write(3'd1, 8'h40);
        #1 check("R8 irq still high at clear", {15'd0, break_irq}, 16'd1);
        reg_read(3'd1, rd); check("R7 read then write 0 clears", {8'd0, rd}, 16'h0040);
        check("R8 irq falls after clear", {15'd0, break_irq}, 16'd0);

        // R8 enable off: flag sets, no request
        reg_write(3'd1, 8'h00);
        bus_cycle(16'h025A, 16'h0000, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        #1 check("R8 irq stays low with enable 0", {15'd0, break_irq}, 16'd0);
        reg_read(3'd1, rd); check("R8 flag set with enable 0", {8'd0, rd}, 16'h0080);
        check("R8 irq low after read", {15'd0, break_irq}, 16'd0);

        // R9 readback
        reg_write(3'd0, 8'hFF);
        reg_read(3'd0, rd); check("R9 ctrl readback", {8'd0, rd}, 16'h00B8);
        reg_write(3'd2, 8'h12);
        reg_write(3'd3, 8'h34);
        reg_write(3'd4, 8'hAB);
        reg_write(3'd5, 8'hCD);
        reg_read(3'd2, rd); check("R9 bar hi", {8'd0, rd}, 16'h0012);
        reg_read(3'd3, rd); check("R9 bar lo", {8'd0, rd}, 16'h0034);
        reg_read(3'd4, rd); check("R9 bdr hi", {8'd0, rd}, 16'h00AB);
        reg_read(3'd5, rd); check("R9 bdr lo", {8'd0, rd}, 16'h00CD);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule